// File: doc/BRIEF.md
# Floating-Point Error Interrupt Latch

This block sits between a processor's active-low floating-point error output and one line of the system interrupt controller, for a legacy compatibility mode. Every assertion of the error signal becomes a sticky interrupt request. A one-clock pulse counts as well. The request stays set after the error signal is released. This covers instructions that raise the error only briefly and then drop it.

The error handler acknowledges the request by writing to I/O port 0F0H. That write clears the request. If the processor is still holding the error signal active at that moment, the write also drives the active-low ignore-numeric-error output. The processor can then continue past the pending error. The ignore output is released as soon as the synchronized error signal goes inactive, so it can never stay set after the handler has cleared the error condition.

The error input is asynchronous and passes through a synchronizer with a parameterized number of stages. Request setting is edge-driven on the synchronized value.

Top module: `fpu_err_irq_latch`

## Requirements
- R1: While reset is asserted, and right after it is released, `irq` is 0 and `ignore_n` is 1.
- R2: An assertion of `fp_err_n` (low) that is sampled by even one rising clock edge sets `irq`. With the default two synchronizer stages, `irq` reads 1 after the third rising edge, counting the edge that first samples the low level.
- R3: Once set, `irq` stays at 1 while `fp_err_n` is released, until an acknowledge write occurs.
- R4: An acknowledge write clears `irq` at the next edge. An acknowledge write is `io_wr`=1, `io_rd`=0 and `io_addr`=0x00F0. If a new synchronized error edge arrives on that same edge, the set wins.
- R5: An acknowledge write made while the synchronized error is active drives `ignore_n` to 0 at the next edge.
- R6: `ignore_n` returns to 1 on the edge after the synchronized error goes inactive. That is the third rising edge after `fp_err_n` is first sampled high.
- R7: An acknowledge write made while the synchronized error is inactive leaves `ignore_n` at 1.
- R8: A read of port 0x00F0, a write to any other address, and a cycle with both `io_rd` and `io_wr` high all leave `irq` and `ignore_n` unchanged.
- R9: After `irq` has been cleared, it sets again only on a new falling transition of the error input. An error level that is held across the acknowledge does not set it again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_err_n | input | 1 | Active-low floating-point error from the processor, asynchronous |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| irq | output | 1 | Active-high interrupt request |
| ignore_n | output | 1 | Active-low ignore-numeric-error back to the processor |

## Verification
The hardest case is an acknowledge write that lands while the synchronized error is still active, followed later by the release of the error. Only this order drives `ignore_n` low, and it checks that the release really frees it. The stimulus holds `fp_err_n` low for many cycles and issues the port write well after `irq` has risen. It then releases the error and watches the three-edge release path. It also retriggers the error within a couple of cycles of an acknowledge, so that a set and a clear compete on the same edge.

// File: rtl/fel_pkg.sv
package fel_pkg;
   localparam int unsigned FEL_ADDR_W      = 16;
   localparam int unsigned FEL_ACK_PORT    = 32'h0000_00F0;
   localparam int unsigned FEL_SYNC_STAGES = 2;
endpackage

// File: rtl/fel_sync.sv
module fel_sync #(
   parameter int unsigned STAGES = fel_pkg::FEL_SYNC_STAGES
) (
   input  logic clk,
   input  logic rst_n,
   input  logic err_n_async,
   output logic err_act,
   output logic err_rise
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("fel_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              act_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= ~err_n_async;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) act_q <= 1'b0;
      else        act_q <= chain[LAST];

   assign err_act  = chain[LAST];
   assign err_rise = chain[LAST] & ~act_q;

   p_rise_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_rise |=> !err_rise);
endmodule

// File: rtl/fel_ack_decode.sv
module fel_ack_decode #(
   parameter int unsigned ADDR_W   = fel_pkg::FEL_ADDR_W,
   parameter int unsigned ACK_PORT = fel_pkg::FEL_ACK_PORT
) (
   input  logic              io_wr,
   input  logic              io_rd,
   input  logic [ADDR_W-1:0] io_addr,
   output logic              ack
);
   localparam logic [ADDR_W-1:0] PORT = ADDR_W'(ACK_PORT);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_width
      $error("fel_ack_decode: ADDR_W out of range");
   end
   if (ACK_PORT >= (64'd1 << ADDR_W)) begin : g_bad_port
      $error("fel_ack_decode: ACK_PORT does not fit ADDR_W");
   end

   assign ack = io_wr & ~io_rd & (io_addr == PORT);

   always_comb
      if (io_rd) p_ack_needs_write_r8: assert (!ack);
endmodule

// File: rtl/fel_req_latch.sv
module fel_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic err_rise,
   input  logic ack,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        irq <= 1'b0;
      else if (err_rise) irq <= 1'b1;
      else if (ack)      irq <= 1'b0;

   p_irq_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      err_rise |=> irq);
   p_irq_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !ack |=> irq);
   p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ack && !err_rise |=> !irq);
   p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $past(err_rise));
endmodule

// File: rtl/fel_ignore_ctl.sv
module fel_ignore_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic err_act,
   input  logic ack,
   output logic ignore_n
);
   logic ign_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        ign_q <= 1'b0;
      else if (!err_act) ign_q <= 1'b0;
      else if (ack)      ign_q <= 1'b1;

   assign ignore_n = ~ign_q;

   p_ign_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ack && err_act |=> !ignore_n);
   p_ign_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !err_act |=> ignore_n);
   p_ign_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ignore_n) |-> $past(ack) && $past(err_act));
endmodule

// File: rtl/fpu_err_irq_latch.sv
module fpu_err_irq_latch #(
   parameter int unsigned ADDR_W      = fel_pkg::FEL_ADDR_W,
   parameter int unsigned ACK_PORT    = fel_pkg::FEL_ACK_PORT,
   parameter int unsigned SYNC_STAGES = fel_pkg::FEL_SYNC_STAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fp_err_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic              io_rd,
   output logic              irq,
   output logic              ignore_n
);
   logic err_act, err_rise, ack;

   fel_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .err_n_async(fp_err_n),
      .err_act(err_act), .err_rise(err_rise));

   fel_ack_decode #(.ADDR_W(ADDR_W), .ACK_PORT(ACK_PORT)) u_dec (
      .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr), .ack(ack));

   fel_req_latch u_req (
      .clk(clk), .rst_n(rst_n), .err_rise(err_rise), .ack(ack), .irq(irq));

   fel_ignore_ctl u_ign (
      .clk(clk), .rst_n(rst_n), .err_act(err_act), .ack(ack),
      .ignore_n(ignore_n));

   p_reset_state_r1: assert property (@(posedge clk)
      !rst_n |=> (!irq && ignore_n) || rst_n);
   p_no_ack_no_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !ack && irq |=> irq);
endmodule

// File: tb/fpu_err_irq_latch_test.sv
module fpu_err_irq_latch_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fp_err_n = 1'b1;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic        io_rd = 1'b0;
   logic        irq, ignore_n;

   int    vectors = 0;
   int    miscompares = 0;
   int    cycles = 0;
   string cur_req = "R1";

   // reference model state
   bit hq[$];
   bit m_irq = 1'b0;
   bit m_ign = 1'b0;

   always #5 clk = ~clk;

   fpu_err_irq_latch uut (
      .clk(clk), .rst_n(rst_n), .fp_err_n(fp_err_n), .io_addr(io_addr),
      .io_wr(io_wr), .io_rd(io_rd), .irq(irq), .ignore_n(ignore_n));

   initial for (int i = 0; i < 4; i++) hq.push_front(1'b0);

   // Model: the error seen by the logic lags the pin by two sampling edges;
   // a request is set by a new 0->1 change of that lagged view.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hq = {1'b0, 1'b0, 1'b0, 1'b0};
         m_irq = 1'b0;
         m_ign = 1'b0;
      end else begin
         bit ackv, seen, seen_prev;
         hq.push_front(~fp_err_n);
         void'(hq.pop_back());
         seen      = hq[2];
         seen_prev = hq[3];
         ackv = io_wr && !io_rd && io_addr == 16'h00F0;
         if (seen && !seen_prev) m_irq = 1'b1;
         else if (ackv)          m_irq = 1'b0;
         if (!seen)     m_ign = 1'b0;
         else if (ackv) m_ign = 1'b1;
      end
   end

   task automatic check(string req, string what, bit act, bit exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d",
                  req, what, act, exp, cycles);
      end
   endtask

   always @(negedge clk) begin
      cycles++;
      check(cur_req, "irq", irq, m_irq);
      check(cur_req, "ignore_n", ignore_n, ~m_ign);
   end

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk)
      if (cycles > 20000) begin
         miscompares++;
         $display("FAIL watchdog expired");
         finish_run();
      end

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic io_cycle(bit wr, bit rd, logic [15:0] a);
      @(negedge clk);
      io_wr = wr; io_rd = rd; io_addr = a;
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0; io_addr = '0;
   endtask

   task automatic err_pulse(int len);
      @(negedge clk);
      fp_err_n = 1'b0;
      idle(len);
      fp_err_n = 1'b1;
   endtask

   initial begin
      // R1: reset state
      cur_req = "R1";
      idle(3);
      check("R1", "irq in reset", irq, 1'b0);
      check("R1", "ignore_n in reset", ignore_n, 1'b1);
      rst_n = 1'b1;
      idle(3);
      check("R1", "irq after reset", irq, 1'b0);

      // R2: one-cycle pulse captured, visible after the third edge
      cur_req = "R2";
      err_pulse(1);
      idle(1);
      check("R2", "irq not yet", irq, 1'b0);
      idle(1);
      check("R2", "irq after pulse", irq, 1'b1);

      // R3: stays latched with error released
      cur_req = "R3";
      idle(12);
      check("R3", "irq held", irq, 1'b1);

      // R8: reads, wrong addresses, simultaneous strobes
      cur_req = "R8";
      io_cycle(1'b0, 1'b1, 16'h00F0);
      io_cycle(1'b1, 1'b0, 16'h00F1);
      io_cycle(1'b1, 1'b0, 16'h01F0);
      io_cycle(1'b1, 1'b1, 16'h00F0);
      check("R8", "irq untouched", irq, 1'b1);
      check("R8", "ignore_n untouched", ignore_n, 1'b1);

      // R4 and R7: ack with error inactive
      cur_req = "R7";
      io_cycle(1'b1, 1'b0, 16'h00F0);
      check("R4", "irq cleared", irq, 1'b0);
      check("R7", "ignore_n stays high", ignore_n, 1'b1);
      idle(4);

      // R5: ack while error held
      cur_req = "R5";
      @(negedge clk) fp_err_n = 1'b0;
      idle(6);
      check("R2", "irq from held error", irq, 1'b1);
      io_cycle(1'b1, 1'b0, 16'h00F0);
      check("R5", "ignore_n low", ignore_n, 1'b0);
      check("R4", "irq cleared while held", irq, 1'b0);

      // R9: held level does not re-set
      cur_req = "R9";
      idle(8);
      check("R9", "no re-set from held level", irq, 1'b0);
      check("R5", "ignore_n still low", ignore_n, 1'b0);

      // R6: release drops ignore
      cur_req = "R6";
      fp_err_n = 1'b1;
      idle(2);
      check("R6", "ignore_n before release seen", ignore_n, 1'b0);
      idle(1);
      check("R6", "ignore_n released", ignore_n, 1'b1);
      idle(3);

      // R9: new pulse after clear sets again
      cur_req = "R9";
      err_pulse(2);
      idle(3);
      check("R9", "irq re-set", irq, 1'b1);

      // R4: new edge competing with ack
      cur_req = "R4";
      io_cycle(1'b1, 1'b0, 16'h00F0);
      idle(2);
      @(negedge clk) fp_err_n = 1'b0;
      idle(2);
      io_addr = 16'h00F0; io_wr = 1'b1;
      idle(1);
      io_wr = 1'b0;
      idle(2);
      fp_err_n = 1'b1;
      idle(4);

      // mixed patterns, checked every cycle against the model
      cur_req = "R2";
      for (int k = 0; k < 300; k++) begin
         @(negedge clk);
         fp_err_n = ((k * 7) % 11) < 3 ? 1'b0 : 1'b1;
         io_wr    = (k % 13) == 5 || (k % 17) == 2;
         io_rd    = (k % 19) == 4;
         io_addr  = (k % 3) == 0 ? 16'h00F1 : 16'h00F0;
      end
      @(negedge clk);
      io_wr = 1'b0; io_rd = 1'b0; fp_err_n = 1'b1;
      idle(5);
      finish_run();
   end
endmodule